// File: doc/BRIEF.md
# Bus-Programmed Watchdog Timer

This block is a watchdog timer that sits on a simple APB-style slave port. A down-counter, as wide as the data bus, moves one step on each pulse of a tick-enable input. The tick-enable input comes from an external divider. When the counter expires, the block raises a raw interrupt flag and drives an interrupt output, masked by the enable bit. On the next tick the counter reloads itself from a programmable load register.

Software arms the block by programming a load value and setting the enable bit. It services the block by writing the interrupt-clear register, which also restarts the count. If the counter expires again while the interrupt is still pending, and reset requests are enabled, the block asserts a reset-request output. That output stays high until the block itself is reset.

A key register protects all the other writable registers against stray writes. A parameter selects a sticky variant. In that variant, once the enable bit is 1, control writes have no effect until reset.

Top module: `pwdt_top`

## Requirements
- R1: After reset, load and current value both read 0xFFFFFFFF, and control, raw status, masked status and lock all read 0. The irq_o and rst_req_o outputs are low.
- R2: Word offsets are: load 0x000, current value 0x004, control 0x008 (bit 0 enable, bit 1 reset-request enable), interrupt clear 0x00C, raw status 0x010 (bit 0), masked status 0x014 (bit 0) and lock 0xC00. Reads of any other offset return 0. pready is always 1 and pslverr is always 0.
- R3: While enable is 1, each cycle with tick_en high lowers the current value by one. While enable is 0, the value holds and no interrupt is raised.
- R4: A write to the load register sets both the load register and the current value to the written data in the same access, whether or not the counter is enabled.
- R5: A tick at value 1 makes the value 0 and sets raw status to 1. The next tick reloads the value from the load register.
- R6: A write of any data to the interrupt-clear register clears raw status and reloads the current value from the load register.
- R7: Writing control bit 0 as 1 while it was 0 reloads the current value from the load register. Clearing bit 0 freezes the value.
- R8: With STICKY_EN=1, once the enable bit is 1, control writes are ignored. Control keeps reading 1, counting continues, and only a reset clears the enable bit.
- R9: Masked status and irq_o equal raw status AND the enable bit.
- R10: With control bit 1 set, an expiry while raw status is already 1 sets rst_req_o, which stays high until reset. With bit 1 clear, rst_req_o stays low.
- R11: A write of 0x1ACCE551 to the lock register unlocks writes. Any other value locks them. Lock reads 1 when locked and 0 when unlocked. While locked, writes to load, control and interrupt clear are ignored.
- R12: Writes to the current value, raw status and masked status registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable pulse from the external divider |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete (always 1) |
| pslverr | output | 1 | Transfer error (always 0) |
| irq_o | output | 1 | Masked watchdog interrupt |
| rst_req_o | output | 1 | Reset request, held until reset |

## Verification
The embedded assertions check properties on every cycle:
- the counter holds while disabled and idle;
- a load write or an interrupt clear restarts the count from the right value;
- a zero count reloads on the next tick;
- the reset request, once set, never drops;
- the sticky enable never clears itself;
- a locked load write leaves the load register unchanged.

Only the bench scenarios can show the full sequences:
- the countdown across a sweep of load values, with expiry and reload at the exact tick;
- reload when the enable bit rises;
- the second-expiry reset request, with and without its enable;
- the lock key;
- the sticky variant surviving a clearing write until reset.

// File: rtl/pwdt_pkg.sv
package pwdt_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_VALUE = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_ICLR  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_MSK   = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_LOCK  = 12'hC00;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LOAD,
    SEL_VALUE,
    SEL_CTRL,
    SEL_ICLR,
    SEL_RAW,
    SEL_MSK,
    SEL_LOCK
  } pwdt_sel_e;
endpackage

// File: rtl/pwdt_rstsync.sv
module pwdt_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/pwdt_decode.sv
module pwdt_decode
  import pwdt_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output pwdt_sel_e         sel
);
  always_comb begin
    case (addr)
      OFS_LOAD:  sel = SEL_LOAD;
      OFS_VALUE: sel = SEL_VALUE;
      OFS_CTRL:  sel = SEL_CTRL;
      OFS_ICLR:  sel = SEL_ICLR;
      OFS_RAW:   sel = SEL_RAW;
      OFS_MSK:   sel = SEL_MSK;
      OFS_LOCK:  sel = SEL_LOCK;
      default:   sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/pwdt_regs.sv
module pwdt_regs
  import pwdt_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter bit          STICKY_EN = 1'b0,
  parameter logic [DW-1:0] KEY     = 32'h1ACC_E551
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  pwdt_sel_e     sel,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cnt,
  input  logic          raw,
  output logic [DW-1:0] load_q,
  output logic          en_q,
  output logic          rre_q,
  output logic          ld_stb,
  output logic          clr_stb,
  output logic          rise_stb,
  output logic [DW-1:0] rdata
);
  localparam logic [DW-1:0] LOAD_RST = {DW{1'b1}};

  logic          open_q;
  logic          open_d;
  logic [DW-1:0] load_d;
  logic          en_d;
  logic          rre_d;
  logic          wr_ok;
  logic          ctrl_frozen;
  logic          ctrl_wr;
  logic          lock_wr;

  generate
    if (STICKY_EN) begin : g_sticky
      assign ctrl_frozen = en_q;
    end else begin : g_plain
      assign ctrl_frozen = 1'b0;
    end
  endgenerate

  assign wr_ok    = wr_stb && open_q;
  assign ld_stb   = wr_ok && (sel == SEL_LOAD);
  assign clr_stb  = wr_ok && (sel == SEL_ICLR);
  assign ctrl_wr  = wr_ok && (sel == SEL_CTRL) && !ctrl_frozen;
  assign rise_stb = ctrl_wr && wdata[0] && !en_q;
  assign lock_wr  = wr_stb && (sel == SEL_LOCK);

  always_comb begin
    load_d = load_q;
    en_d   = en_q;
    rre_d  = rre_q;
    open_d = open_q;
    if (ld_stb) begin
      load_d = wdata;
    end
    if (ctrl_wr) begin
      en_d  = wdata[0];
      rre_d = wdata[1];
    end
    if (lock_wr) begin
      open_d = (wdata == KEY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= LOAD_RST;
    end else if (ld_stb) begin
      load_q <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rre_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q  <= en_d;
      rre_q <= rre_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b1;
    end else if (lock_wr) begin
      open_q <= open_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_LOAD:  rdata = load_q;
      SEL_VALUE: rdata = cnt;
      SEL_CTRL:  rdata = {{(DW-2){1'b0}}, rre_q, en_q};
      SEL_RAW:   rdata = {{(DW-1){1'b0}}, raw};
      SEL_MSK:   rdata = {{(DW-1){1'b0}}, raw & en_q};
      SEL_LOCK:  rdata = {{(DW-1){1'b0}}, !open_q};
      default:   rdata = '0;
    endcase
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (STICKY_EN && en_q) |=> en_q); // R8
  AST_LOCKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && wr_stb && sel == SEL_LOAD) |=> $stable(load_q)); // R11
endmodule

// File: rtl/pwdt_count.sv
module pwdt_count #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          rre,
  input  logic [DW-1:0] load,
  input  logic          ld_stb,
  input  logic [DW-1:0] ld_val,
  input  logic          clr_stb,
  input  logic          rise_stb,
  output logic [DW-1:0] cnt_q,
  output logic          raw_q,
  output logic          rreq_q
);
  localparam logic [DW-1:0] CNT_RST = {DW{1'b1}};
  localparam logic [DW-1:0] ONE     = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] cnt_d;
  logic          raw_d;
  logic          rreq_d;
  logic          step;
  logic          bus_op;
  logic          ce;

  assign step   = tick && en;
  assign bus_op = ld_stb || clr_stb || rise_stb;
  assign ce     = bus_op || step;

  always_comb begin
    cnt_d  = cnt_q;
    raw_d  = raw_q;
    rreq_d = rreq_q;
    if (ld_stb) begin
      cnt_d = ld_val;
    end else if (clr_stb) begin
      cnt_d = load;
      raw_d = 1'b0;
    end else if (rise_stb) begin
      cnt_d = load;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_d = load;
      end else begin
        cnt_d = cnt_q - ONE;
        if (cnt_q == ONE) begin
          raw_d = 1'b1;
          if (raw_q && rre) begin
            rreq_d = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_RST;
      raw_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else if (ce) begin
      cnt_q  <= cnt_d;
      raw_q  <= raw_d;
      rreq_q <= rreq_d;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !bus_op) |=> $stable(cnt_q)); // R3
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> (cnt_q == $past(ld_val))); // R4
  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !bus_op && cnt_q == '0) |=> (cnt_q == $past(load))); // R5
  AST_CLR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> (!raw_q && cnt_q == $past(load))); // R6
  AST_RREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |=> rreq_q); // R10
endmodule

// File: rtl/pwdt_top.sv
module pwdt_top
  import pwdt_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter bit          STICKY_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic          rst_i_n;
  pwdt_sel_e     sel;
  logic          wr_stb;
  logic [DW-1:0] load_q;
  logic [DW-1:0] cnt_q;
  logic          en_q;
  logic          rre_q;
  logic          raw_q;
  logic          ld_stb;
  logic          clr_stb;
  logic          rise_stb;

  assign wr_stb  = psel && penable && pwrite;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  pwdt_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pwdt_decode u_dec (
    .addr (paddr),
    .sel  (sel)
  );

  pwdt_regs #(
    .DW        (DW),
    .STICKY_EN (STICKY_EN)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_stb   (wr_stb),
    .sel      (sel),
    .wdata    (pwdata),
    .cnt      (cnt_q),
    .raw      (raw_q),
    .load_q   (load_q),
    .en_q     (en_q),
    .rre_q    (rre_q),
    .ld_stb   (ld_stb),
    .clr_stb  (clr_stb),
    .rise_stb (rise_stb),
    .rdata    (prdata)
  );

  pwdt_count #(
    .DW (DW)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .tick     (tick_en),
    .en       (en_q),
    .rre      (rre_q),
    .load     (load_q),
    .ld_stb   (ld_stb),
    .ld_val   (pwdata),
    .clr_stb  (clr_stb),
    .rise_stb (rise_stb),
    .cnt_q    (cnt_q),
    .raw_q    (raw_q),
    .rreq_q   (rst_req_o)
  );

  assign irq_o = raw_q & en_q;
endmodule

// File: tb/sim_pwdt_top.sv
module sim_pwdt_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        psel0 = 1'b0;
  logic        psel1 = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata0, prdata1;
  logic        pready0, pready1, pslverr0, pslverr1;
  logic        irq0, irq1, rreq0, rreq1;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pwdt_top #(.STICKY_EN(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel0),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata0), .pready(pready0), .pslverr(pslverr0),
    .irq_o(irq0), .rst_req_o(rreq0));

  pwdt_top #(.STICKY_EN(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel1),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata1), .pready(pready1), .pslverr(pslverr1),
    .irq_o(irq1), .rst_req_o(rreq1));

  localparam logic [11:0] A_LOAD = 12'h000, A_VAL = 12'h004, A_CTRL = 12'h008,
                          A_ICLR = 12'h00C, A_RAW = 12'h010, A_MSK = 12'h014,
                          A_LOCK = 12'hC00;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel0 = (i == 0); psel1 = (i == 1); penable = 1'b0; pwrite = 1'b1;
    paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel0 = 1'b0; psel1 = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input int i, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel0 = (i == 0); psel1 = (i == 1); penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = (i == 1) ? prdata1 : prdata0;
    @(negedge clk);
    psel0 = 1'b0; psel1 = 1'b0; penable = 1'b0;
  endtask

  task automatic rchk(input string req, input int i, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(i, a, d);
    chk(req, d, exp);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset state
    rchk("R1 load", 0, A_LOAD, 32'hFFFF_FFFF);
    rchk("R1 value", 0, A_VAL, 32'hFFFF_FFFF);
    rchk("R1 ctrl", 0, A_CTRL, 0);
    rchk("R1 raw", 0, A_RAW, 0);
    rchk("R1 masked", 0, A_MSK, 0);
    rchk("R1 lock", 0, A_LOCK, 0);
    chk("R1 irq", {31'b0, irq0}, 0);
    chk("R1 rst_req", {31'b0, rreq0}, 0);

    // R2 unmapped offsets and handshake
    rchk("R2 unmapped 0x018", 0, 12'h018, 0);
    rchk("R2 unmapped 0x800", 0, 12'h800, 0);
    rchk("R2 unmapped 0xC04", 0, 12'hC04, 0);
    chk("R2 pready", {31'b0, pready0}, 1);
    chk("R2 pslverr", {31'b0, pslverr0}, 0);

    // R4 load while disabled, R3 no counting while disabled
    wr(0, A_LOAD, 32'd4000);
    rchk("R4 load reg", 0, A_LOAD, 32'd4000);
    rchk("R4 value follows", 0, A_VAL, 32'd4000);
    ticks(5);
    rchk("R3 held while disabled", 0, A_VAL, 32'd4000);

    // Sweep load values: R3 countdown, R5 expiry/reload, R9 mask, R6 clear
    for (int L = 1; L <= 6; L++) begin
      wr(0, A_CTRL, 0);
      wr(0, A_LOAD, L);
      wr(0, A_CTRL, 1);
      for (int k = 1; k < L; k++) begin
        ticks(1);
        rchk("R3 countdown", 0, A_VAL, L - k);
        rchk("R5 no early raw", 0, A_RAW, 0);
      end
      ticks(1);
      rchk("R5 expiry value", 0, A_VAL, 0);
      rchk("R5 expiry raw", 0, A_RAW, 1);
      rchk("R9 masked set", 0, A_MSK, 1);
      chk("R9 irq high", {31'b0, irq0}, 1);
      ticks(1);
      rchk("R5 reload", 0, A_VAL, L);
      wr(0, A_ICLR, 32'hDEAD_BEEF);
      rchk("R6 raw cleared", 0, A_RAW, 0);
      rchk("R6 reloaded", 0, A_VAL, L);
      chk("R9 irq low", {31'b0, irq0}, 0);
    end

    // R6 clear mid-count
    wr(0, A_LOAD, 8);
    ticks(3);
    wr(0, A_ICLR, 0);
    rchk("R6 mid-count reload", 0, A_VAL, 8);

    // R9 masked follows enable while raw pending
    wr(0, A_LOAD, 1);
    ticks(1);
    wr(0, A_CTRL, 0);
    rchk("R9 raw kept", 0, A_RAW, 1);
    rchk("R9 masked off", 0, A_MSK, 0);
    chk("R9 irq masked", {31'b0, irq0}, 0);
    wr(0, A_CTRL, 1);
    wr(0, A_ICLR, 0);

    // R7 freeze and rising reload
    wr(0, A_LOAD, 10);
    ticks(3);
    rchk("R7 running", 0, A_VAL, 7);
    wr(0, A_CTRL, 0);
    ticks(4);
    rchk("R7 frozen", 0, A_VAL, 7);
    wr(0, A_CTRL, 1);
    rchk("R7 reload on enable", 0, A_VAL, 10);

    // R12 read-only registers ignore writes
    rd(0, A_VAL, v);
    wr(0, A_VAL, 32'd55);
    rchk("R12 value write ignored", 0, A_VAL, v);
    wr(0, A_RAW, 1);
    rchk("R12 raw write ignored", 0, A_RAW, 0);
    wr(0, A_MSK, 1);
    rchk("R12 masked write ignored", 0, A_MSK, 0);

    // R10 without reset-request enable: second expiry gives no request
    wr(0, A_CTRL, 0);
    wr(0, A_LOAD, 1);
    wr(0, A_CTRL, 1);
    ticks(3);
    chk("R10 no request when disabled", {31'b0, rreq0}, 0);
    wr(0, A_ICLR, 0);

    // R10 with reset-request enable
    wr(0, A_CTRL, 0);
    wr(0, A_LOAD, 2);
    wr(0, A_CTRL, 3);
    rchk("R2 ctrl bit1", 0, A_CTRL, 3);
    ticks(2);
    rchk("R10 first expiry raw", 0, A_RAW, 1);
    chk("R10 no request first", {31'b0, rreq0}, 0);
    ticks(3);
    rchk("R10 second expiry value", 0, A_VAL, 0);
    chk("R10 request on second expiry", {31'b0, rreq0}, 1);
    wr(0, A_ICLR, 0);
    ticks(2);
    chk("R10 request held", {31'b0, rreq0}, 1);

    // R11 lock
    wr(0, A_LOCK, 32'h0000_0000);
    rchk("R11 locked reads 1", 0, A_LOCK, 1);
    wr(0, A_LOAD, 32'd77);
    rchk("R11 load write blocked", 0, A_LOAD, 2);
    wr(0, A_CTRL, 0);
    rchk("R11 ctrl write blocked", 0, A_CTRL, 3);
    wr(0, A_LOCK, 32'h1ACC_E551);
    rchk("R11 unlocked reads 0", 0, A_LOCK, 0);
    wr(0, A_LOAD, 32'd77);
    rchk("R11 load write after unlock", 0, A_LOAD, 77);

    // R8 sticky variant on u1
    wr(1, A_LOAD, 20);
    wr(1, A_CTRL, 1);
    ticks(2);
    rchk("R8 sticky counting", 1, A_VAL, 18);
    wr(1, A_CTRL, 0);
    rchk("R8 ctrl stays 1", 1, A_CTRL, 1);
    ticks(2);
    rchk("R8 still counting", 1, A_VAL, 16);
    wr(1, A_CTRL, 3);
    rchk("R8 ctrl write ignored", 1, A_CTRL, 1);

    do_reset();
    rchk("R8 reset clears ctrl", 1, A_CTRL, 0);
    rchk("R1 load after reset", 1, A_LOAD, 32'hFFFF_FFFF);
    ticks(3);
    rchk("R3 idle after reset", 1, A_VAL, 32'hFFFF_FFFF);
    chk("R10 request cleared by reset", {31'b0, rreq0}, 0);

    finish_run();
  end
endmodule